// File: doc/BRIEF.md
# DMA Descriptor Chain Fetcher

The fetcher follows a sequence of four-word DMA descriptors held in system memory and turns each one into buffer work items for a data mover. After a start pulse it reads the descriptor at the base address as a single four-beat burst on a master read port. It decodes the words into a control word, a size word and two address words. It then offers one or two buffer (address, byte count) pairs to the mover, one after the other, and moves on to the next descriptor.

A chain flag in the control word sets the meaning of the fourth word. When the flag is set, the fourth word is a pointer to the next descriptor. When it is clear, the fourth word is a second data buffer, and the next descriptor sits directly after the current one in memory. The walk ends once the buffers of a descriptor carrying the last flag have been accepted. The block then raises a done flag and returns to idle.

Top module: `desc_fetch`

## Requirements
- R1: After reset, idle_o is 1, done_o is 0, and neither rd_req_o nor buf_valid_o is asserted.
- R2: A descriptor read raises rd_req_o with the descriptor address, bits 1:0 forced to zero. The request and its address are held until rd_gnt_i is sampled high. Exactly four rd_valid_i beats then follow and are taken as words 0 to 3 in order.
- R3: Word layout. Word 0 is the control word: bit 4 is the chain flag and bit 2 is the last flag, and all other bits are ignored. Word 1 bits 12:0 hold the first buffer size and bits 25:13 the second. Word 2 is the first buffer address. Word 3 is the second buffer address or the next-descriptor pointer.
- R4: A buffer is offered on buf_valid_o. Its buf_addr_o and buf_size_o are held until buf_ack_i is sampled high. The first buffer of a descriptor is always offered before the second.
- R5: Every buffer address on buf_addr_o has bits 1:0 cleared. The byte count is the size field unchanged.
- R6: With the chain flag set, only the first buffer is offered, even if the second size is nonzero. The next descriptor is read from word 3 with bits 1:0 cleared.
- R7: With the chain flag clear, the second buffer (word 3, second size) is offered after the first. The next descriptor is read from the current descriptor address plus 16.
- R8: A buffer whose size field is zero is never offered. The fetcher passes over it without waiting for buf_ack_i.
- R9: Once the buffers of a descriptor with the last flag are acknowledged, no further read is issued, done_o and idle_o go to 1, and done_o returns to 0 on the next start_i.
- R10: A descriptor read is never requested while a buffer is being offered. The next read starts only after all buffers of the current descriptor are acknowledged or skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| base_addr_i | input | 32 | Address of the first descriptor |
| rd_req_o | output | 1 | Descriptor burst read request |
| rd_addr_o | output | 32 | Word-aligned address of the burst |
| rd_gnt_i | input | 1 | Read request accepted |
| rd_valid_i | input | 1 | Read data beat valid |
| rd_data_i | input | 32 | Read data beat |
| buf_valid_o | output | 1 | Buffer work item offered |
| buf_addr_o | output | 32 | Word-aligned buffer address |
| buf_size_o | output | 13 | Buffer byte count |
| buf_ack_i | input | 1 | Mover accepted the buffer |
| idle_o | output | 1 | No walk in progress |
| done_o | output | 1 | Last descriptor finished |

## Verification
The walk is exercised with four descriptor patterns, and each one separates a different failure.
- A chained list scattered through memory uses unaligned pointers and a nonzero unused second size. It shows whether the next address really comes from word 3, whether low bits are dropped, and whether the second buffer is correctly suppressed.
- A contiguous dual-buffer run shows whether the plus-16 stepping and the first-then-second order are right.
- A mix of zero-sized buffers, including a descriptor with both sizes zero, tells skipping apart from offering empty work.
- A single last descriptor whose pointer leads back into an earlier list shows whether the walk truly stops rather than following the pointer.

// File: rtl/desc_fetch_pkg.sv
package desc_fetch_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_BEATS = 4;
  localparam int DESC_BYTES = DESC_BEATS * WORD_W / 8;
  localparam int CHAIN_BIT  = 4;
  localparam int LAST_BIT   = 2;
  localparam int SIZE_W     = 13;
  localparam int ALIGN_W    = 2;

  typedef logic [DESC_BEATS-1:0][WORD_W-1:0] desc_raw_t;

  typedef struct packed {
    logic              chain;
    logic              last;
    logic [SIZE_W-1:0] size1;
    logic [SIZE_W-1:0] size2;
    logic [WORD_W-1:0] addr1;
    logic [WORD_W-1:0] addr2;
  } desc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_BUF1,
    ST_BUF2,
    ST_ADV
  } fsm_t;
endpackage

// File: rtl/desc_reader.sv
module desc_reader
  import desc_fetch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [WORD_W-1:0] addr_i,
  output logic              rd_req_o,
  output logic [WORD_W-1:0] rd_addr_o,
  input  logic              rd_gnt_i,
  input  logic              rd_valid_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output desc_raw_t         words_o,
  output logic              done_o
);
  localparam int BW = $clog2(DESC_BEATS);

  logic          req_q, recv_q;
  logic [BW-1:0] beat_q;
  logic [WORD_W-1:0] addr_q;
  logic          unused_low;

  assign unused_low = ^addr_i[ALIGN_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      recv_q <= 1'b0;
      beat_q <= '0;
      addr_q <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        req_q  <= 1'b1;
        addr_q <= {addr_i[WORD_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
      end else if (req_q && rd_gnt_i) begin
        req_q  <= 1'b0;
        recv_q <= 1'b1;
        beat_q <= '0;
      end else if (recv_q && rd_valid_i) begin
        beat_q <= beat_q + 1'b1;
        if (beat_q == BW'(DESC_BEATS - 1)) begin
          recv_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  for (genvar k = 0; k < DESC_BEATS; k++) begin : g_word
    logic [WORD_W-1:0] w_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) w_q <= '0;
      else if (recv_q && rd_valid_i && beat_q == BW'(k)) w_q <= rd_data_i;
    end
    assign words_o[k] = w_q;
  end

  assign rd_req_o  = req_q;
  assign rd_addr_o = addr_q;
endmodule

// File: rtl/desc_decode.sv
module desc_decode
  import desc_fetch_pkg::*;
(
  input  desc_raw_t raw_i,
  output desc_t     desc_o
);
  logic unused_raw;
  assign unused_raw = ^raw_i;

  always_comb begin
    desc_o.chain = raw_i[0][CHAIN_BIT];
    desc_o.last  = raw_i[0][LAST_BIT];
    desc_o.size1 = raw_i[1][SIZE_W-1:0];
    desc_o.size2 = raw_i[1][2*SIZE_W-1:SIZE_W];
    desc_o.addr1 = {raw_i[2][WORD_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    desc_o.addr2 = {raw_i[3][WORD_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
  end
endmodule

// File: rtl/desc_fetch.sv
module desc_fetch
  import desc_fetch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] base_addr_i,
  output logic              rd_req_o,
  output logic [WORD_W-1:0] rd_addr_o,
  input  logic              rd_gnt_i,
  input  logic              rd_valid_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              buf_valid_o,
  output logic [WORD_W-1:0] buf_addr_o,
  output logic [SIZE_W-1:0] buf_size_o,
  input  logic              buf_ack_i,
  output logic              idle_o,
  output logic              done_o
);
  fsm_t              state_q;
  logic [WORD_W-1:0] cur_q, next_addr, go_addr;
  logic              done_q, go, rd_done;
  desc_raw_t         raw;
  desc_t             desc;
  logic              b1_live, b2_live;

  desc_reader u_reader (
    .clk_i,
    .rst_ni,
    .go_i      (go),
    .addr_i    (go_addr),
    .rd_req_o,
    .rd_addr_o,
    .rd_gnt_i,
    .rd_valid_i,
    .rd_data_i,
    .words_o   (raw),
    .done_o    (rd_done)
  );

  desc_decode u_decode (
    .raw_i  (raw),
    .desc_o (desc)
  );

  assign next_addr = desc.chain ? desc.addr2 : cur_q + WORD_W'(DESC_BYTES);
  assign go        = (state_q == ST_IDLE && start_i) || (state_q == ST_ADV && !desc.last);
  assign go_addr   = (state_q == ST_IDLE) ? base_addr_i : next_addr;
  assign b1_live   = desc.size1 != '0;
  assign b2_live   = desc.size2 != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      if (go) cur_q <= {go_addr[WORD_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_FETCH;
          done_q  <= 1'b0;
        end
        ST_FETCH: if (rd_done) state_q <= ST_BUF1;
        ST_BUF1: if (!b1_live || buf_ack_i) state_q <= desc.chain ? ST_ADV : ST_BUF2;
        ST_BUF2: if (!b2_live || buf_ack_i) state_q <= ST_ADV;
        ST_ADV: begin
          if (desc.last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // second slot only reached in dual-buffer mode
  assign buf_valid_o = (state_q == ST_BUF1 && b1_live) || (state_q == ST_BUF2 && b2_live);
  assign buf_addr_o  = (state_q == ST_BUF2) ? desc.addr2 : desc.addr1;
  assign buf_size_o  = (state_q == ST_BUF2) ? desc.size2 : desc.size1;
  assign idle_o      = state_q == ST_IDLE;
  assign done_o      = done_q;
endmodule

// File: rtl/desc_fetch_chk.sv
module desc_fetch_chk
  import desc_fetch_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_req_o,
  input logic [WORD_W-1:0] rd_addr_o,
  input logic              rd_gnt_i,
  input logic              buf_valid_o,
  input logic [WORD_W-1:0] buf_addr_o,
  input logic [SIZE_W-1:0] buf_size_o,
  input logic              buf_ack_i,
  input logic              idle_o,
  input logic              done_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_gnt_i |=> rd_req_o && $stable(rd_addr_o)); // R2
  AST_REQ_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o[ALIGN_W-1:0] == '0); // R2
  AST_BUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_valid_o && !buf_ack_i |=> buf_valid_o && $stable(buf_addr_o) && $stable(buf_size_o)); // R4
  AST_BUF_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_valid_o |-> buf_addr_o[ALIGN_W-1:0] == '0); // R5
  AST_NO_EMPTY_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_valid_o |-> buf_size_o != '0); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> idle_o); // R9
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && buf_valid_o)); // R10
endmodule

bind desc_fetch desc_fetch_chk u_chk (.*);

// File: tb/desc_fetch_test.sv
module desc_fetch_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_addr_i = '0;
  logic        rd_req_o;
  logic [31:0] rd_addr_o;
  logic        rd_gnt_i = 1'b0;
  logic        rd_valid_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic        buf_valid_o;
  logic [31:0] buf_addr_o;
  logic [12:0] buf_size_o;
  logic        buf_ack_i = 1'b0;
  logic        idle_o, done_o;

  desc_fetch uut (.*);

  always #10 clk_i = ~clk_i;

  logic [31:0] mem [0:63];
  logic [31:0] f_addr [0:15];
  logic [31:0] b_addr [0:15];
  logic [12:0] b_size [0:15];
  int n_fetch = 0, n_buf = 0, overlap = 0;
  int checks = 0, errors = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input logic chain, input logic last);
    return 32'h8000_0001 | (32'(chain) << 4) | (32'(last) << 2);
  endfunction

  function automatic logic [31:0] sizes(input logic [12:0] s1, input logic [12:0] s2);
    return 32'hFC00_0000 | (32'(s2) << 13) | 32'(s1);
  endfunction

  task automatic put_desc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3);
    mem[a[7:2]]       = w0;
    mem[a[7:2] + 6'd1] = w1;
    mem[a[7:2] + 6'd2] = w2;
    mem[a[7:2] + 6'd3] = w3;
  endtask

  // memory responder: grant after one wait cycle, then four beats
  initial begin
    forever begin
      @(negedge clk_i);
      if (rd_req_o) begin
        logic [5:0] idx;
        idx = rd_addr_o[7:2];
        if (n_fetch < 16) f_addr[n_fetch] = rd_addr_o;
        n_fetch++;
        @(negedge clk_i);
        rd_gnt_i = 1'b1;
        @(negedge clk_i);
        rd_gnt_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
          rd_valid_i = 1'b1;
          rd_data_i  = mem[idx + 6'(k)];
          @(negedge clk_i);
        end
        rd_valid_i = 1'b0;
      end
    end
  end

  // data mover: log the item, ack one cycle later
  initial begin
    forever begin
      @(negedge clk_i);
      buf_ack_i = 1'b0;
      if (rd_req_o && buf_valid_o) overlap++;
      if (buf_valid_o) begin
        if (n_buf < 16) begin
          b_addr[n_buf] = buf_addr_o;
          b_size[n_buf] = buf_size_o;
        end
        n_buf++;
        @(negedge clk_i);
        buf_ack_i = 1'b1;
      end
    end
  end

  task automatic run_walk(input logic [31:0] base);
    n_fetch = 0;
    n_buf   = 0;
    @(negedge clk_i);
    base_addr_i = base;
    start_i     = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R9 done cleared by start", 32'(done_o), 32'd0);
    for (int i = 0; i < 600 && !done_o; i++) @(negedge clk_i);
    check("R9 done reached", 32'(done_o), 32'd1);
    check("R9 idle after last", 32'(idle_o), 32'd1);
  endtask

  task automatic exp_buf(input string req, input int i, input logic [31:0] a, input logic [12:0] s);
    check({req, " buffer addr"}, b_addr[i], a);
    check({req, " buffer size"}, 32'(b_size[i]), 32'(s));
  endtask

  task automatic t_reset;
    check("R1 idle", 32'(idle_o), 32'd1);
    check("R1 done", 32'(done_o), 32'd0);
    check("R1 rd_req", 32'(rd_req_o), 32'd0);
    check("R1 buf_valid", 32'(buf_valid_o), 32'd0);
  endtask

  task automatic t_chain;
    put_desc(32'h40, ctl(1, 0), sizes(13'h64, 13'h55), 32'h1001, 32'h0A2);
    put_desc(32'hA0, ctl(1, 0), sizes(13'h8, 13'h0), 32'h2003, 32'h013);
    put_desc(32'h10, ctl(1, 1), sizes(13'h1FFF, 13'h7), 32'h3000, 32'h0F0);
    run_walk(32'h40);
    check("R6 fetch count", n_fetch, 3);
    check("R2 fetch 0", f_addr[0], 32'h40);
    check("R6 fetch 1 from pointer", f_addr[1], 32'hA0);
    check("R6 fetch 2 from pointer", f_addr[2], 32'h10);
    check("R6 one buffer per descriptor", n_buf, 3);
    exp_buf("R5", 0, 32'h1000, 13'h64);
    exp_buf("R3", 1, 32'h2000, 13'h8);
    exp_buf("R3", 2, 32'h3000, 13'h1FFF);
  endtask

  task automatic t_dual;
    put_desc(32'h80, ctl(0, 0), sizes(13'h10, 13'h20), 32'h4000, 32'h5000);
    put_desc(32'h90, ctl(0, 1), sizes(13'h4, 13'h100), 32'h6000, 32'h7002);
    run_walk(32'h80);
    check("R7 fetch count", n_fetch, 2);
    check("R7 next at plus 16", f_addr[1], 32'h90);
    check("R7 buffer count", n_buf, 4);
    exp_buf("R4", 0, 32'h4000, 13'h10);
    exp_buf("R7", 1, 32'h5000, 13'h20);
    exp_buf("R4", 2, 32'h6000, 13'h4);
    exp_buf("R7", 3, 32'h7000, 13'h100);
  endtask

  task automatic t_zero;
    put_desc(32'h00, ctl(0, 0), sizes(13'h0, 13'h30), 32'hAAA0, 32'h8000);
    put_desc(32'h10, ctl(0, 0), sizes(13'h0, 13'h0), 32'hBBB0, 32'hCCC0);
    put_desc(32'h20, ctl(0, 1), sizes(13'h40, 13'h0), 32'h9000, 32'hDDD0);
    run_walk(32'h00);
    check("R8 fetch count", n_fetch, 3);
    check("R8 zero buffers skipped", n_buf, 2);
    exp_buf("R8", 0, 32'h8000, 13'h30);
    exp_buf("R8", 1, 32'h9000, 13'h40);
  endtask

  task automatic t_last;
    put_desc(32'hC0, ctl(1, 1), sizes(13'h2C, 13'h0), 32'hE000, 32'h40);
    run_walk(32'hC1);
    check("R2 unaligned base fetched aligned", f_addr[0], 32'hC0);
    repeat (20) @(negedge clk_i);
    check("R9 no fetch after last", n_fetch, 1);
    check("R9 single buffer", n_buf, 1);
    exp_buf("R9", 0, 32'hE000, 13'h2C);
    check("R10 no read during buffer offer", overlap, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_chain;
    t_dual;
    t_zero;
    t_last;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule